// File: doc/BRIEF.md
# Ready-Flagged Conversion Word Sequencer

This block is the digital back end of a slow, pin-configured converter. It keeps the update-rate timing, runs settling after a configuration change or a power-up, and presents each finished conversion on one output line. That line works first as a ready flag and then as the serial data line. Conversion results arrive on a simple valid port. The block publishes the most recently captured result at each update instant, once the filter has settled. A host sees the line fall, then clocks out a 32-bit word with its own serial clock.

The word holds the 24-bit offset-binary code followed by a status byte. The status byte reports the rate and gain settings, an out-of-range flag and two fixed check patterns. A result can be read only once. If it is not read, it is withdrawn a fixed number of ticks before the next update. Any edge on the rate or gain pins discards the current word and restarts settling. Holding the power-down pin low resets everything, floats the line and opens the bridge supply switch.

Top module: `rdy_word_seq`

## Requirements
- R1: With `rate_sel` low the update period is `PER_FAST` clock ticks and settling takes 2 periods. With `rate_sel` high the period is `PER_SLOW` ticks and settling takes 3 periods. The first result is flagged after settling completes, counted from the restart.
- R2: The block sees a level change on `rate_sel` or `gain_sel` three clock edges after the change: two synchroniser stages and one edge-detect stage. On that edge `dr_out` goes high, any pending word is dropped and settling restarts.
- R3: While `pd_n` is low, `dr_oe` and `bridge_on` are low. They fall asynchronously, with no clock edge needed, so a pulse of any width resets the block.
- R4: After `pd_n` rises, `dr_oe` and `bridge_on` go high after the second clock edge and `dr_out` is driven high. The block then waits `WAKE_TICKS` ticks and runs full settling. The first word is flagged `2 + WAKE_TICKS + settle*period` edges after the release.
- R5: A published word drives `dr_out` low. After the third clock edge following each synchronised `sclk` falling edge, `dr_out` shows the next bit, MSB first, for 32 bits.
- R6: Word bits [7:0] are the status byte, sent in this order: bit 7 ready (0), bit 6 rate (1 = `rate_sel` high), bit 5 out-of-range, bits 4:3 fixed 0 then 1, bit 2 gain (1 = `gain_sel` high), bits 1:0 fixed 0 then 1.
- R7: After the 32nd rising `sclk` edge, `dr_out` returns high, with the same three-edge latency. Further `sclk` edges leave it high until the next word.
- R8: An unread word is withdrawn `EARLY_TICKS` ticks before the next update, and `dr_out` goes high. `sclk` edges during the withdrawal leave the line high.
- R9: Each new word restarts the shifter at the MSB. Bits left unread from an earlier word are lost.
- R10: Word bits [31:8] carry, unchanged, the last code captured on a cycle with `res_valid` high. The code is offset binary: 0x000000, 0x800000 and 0xFFFFFF pass through as they are.
- R11: Once settled, words appear once per period. A word left unread stays low for `period - EARLY_TICKS` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock (tick) |
| pd_n | input | 1 | Power-down/reset, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| rate_sel | input | 1 | Update-rate select, low = fast, high = slow |
| gain_sel | input | 1 | Gain select, reported in the status byte |
| res_valid | input | 1 | Result strobe from the conversion datapath |
| res_code | input | 24 | Offset-binary conversion code |
| res_ovr | input | 1 | Result was out of range |
| dr_out | output | 1 | Ready flag / serial data |
| dr_oe | output | 1 | Output enable for `dr_out` |
| bridge_on | output | 1 | Bridge supply switch closed |

## Verification
The assertions check relations that must hold on every cycle. A configuration edge or a withdrawal raises the line on the next cycle. A publish lowers it. The line holds its value when no serial edge, load or kill is present, and it rises after the final rising edge of a read. Two publishes never land on adjacent cycles, and each counting phase starts from zero. Only the bench scenarios can show the absolute timing: the wake-plus-settle delay for each rate, the withdrawal window, the exact bit contents of the word and the status byte, and the loss of a partly read word. The bench shows these by comparing the line each cycle against a behavioural timing model and by reading whole words as a host would.

// File: rtl/rdy_seq_pkg.sv
package rdy_seq_pkg;

  typedef enum logic {
    SEQ_WAKE = 1'b0,
    SEQ_CONV = 1'b1
  } seq_state_e;

  localparam int CODE_W   = 24;
  localparam int STATUS_W = 8;
  localparam int WORD_W   = CODE_W + STATUS_W;

  // Status byte, MSB first: ready(0), rate, range error, 0, 1, gain, 0, 1
  function automatic logic [STATUS_W-1:0] status_byte(input logic slow,
                                                      input logic ovr,
                                                      input logic unity);
    return {1'b0, slow, ovr, 2'b01, unity, 2'b01};
  endfunction

endpackage

// File: rtl/cnv_pin_sync.sv
module cnv_pin_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign q   = sync_q;
  assign q_d = last_q;

endmodule

// File: rtl/cnv_period_ctrl.sv
module cnv_period_ctrl
  import rdy_seq_pkg::*;
#(
  parameter int PER_FAST    = 3840,
  parameter int PER_SLOW    = 6400,
  parameter int WAKE_TICKS  = 64,
  parameter int EARLY_TICKS = 32,
  parameter int SETTLE_FAST = 2,
  parameter int SETTLE_SLOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_sel,
  input  logic restart,
  output logic publish,
  output logic early,
  output logic in_conv
);

  localparam int PER_MAX  = (PER_SLOW > PER_FAST) ? PER_SLOW : PER_FAST;
  localparam int TICK_MAX = (WAKE_TICKS > PER_MAX) ? WAKE_TICKS : PER_MAX;
  localparam int CW       = $clog2(TICK_MAX + 1);
  localparam int SMAX     = (SETTLE_SLOW > SETTLE_FAST) ? SETTLE_SLOW : SETTLE_FAST;
  localparam int SW       = $clog2(SMAX + 1);

  seq_state_e      state_q, state_d;
  logic [CW-1:0]   tick_q, tick_d;
  logic [SW-1:0]   conv_q, conv_d;
  logic [CW-1:0]   per_m1, early_at;
  logic [SW-1:0]   settle_m1;
  logic            upd;

  always_comb begin
    per_m1    = slow_sel ? CW'(PER_SLOW - 1) : CW'(PER_FAST - 1);
    settle_m1 = slow_sel ? SW'(SETTLE_SLOW - 1) : SW'(SETTLE_FAST - 1);
    early_at  = per_m1 - CW'(EARLY_TICKS);
  end

  always_comb begin
    state_d = state_q;
    tick_d  = tick_q;
    conv_d  = conv_q;
    upd     = 1'b0;
    unique case (state_q)
      SEQ_WAKE: begin
        if (tick_q == CW'(WAKE_TICKS - 1)) begin
          state_d = SEQ_CONV;
          tick_d  = '0;
          conv_d  = '0;
        end else begin
          tick_d = tick_q + 1'b1;
        end
      end
      SEQ_CONV: begin
        if (restart) begin
          tick_d = '0;
          conv_d = '0;
        end else if (tick_q == per_m1) begin
          tick_d = '0;
          upd    = 1'b1;
          if (conv_q != SW'(SMAX)) conv_d = conv_q + 1'b1;
        end else begin
          tick_d = tick_q + 1'b1;
        end
      end
      default: state_d = SEQ_WAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_WAKE;
      tick_q  <= '0;
      conv_q  <= '0;
    end else begin
      state_q <= state_d;
      tick_q  <= tick_d;
      conv_q  <= conv_d;
    end
  end

  assign in_conv = (state_q == SEQ_CONV);
  assign publish = upd && (conv_q >= settle_m1);
  assign early   = in_conv && !restart && (tick_q == early_at);

  AST_PUBLISH_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    publish |=> !publish); // R11
  AST_CONV_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_conv) |-> (tick_q == '0) && (conv_q == '0)); // R4
  AST_EARLY_NOT_PUBLISH: assert property (@(posedge clk) disable iff (!rst_n)
    !(publish && early)); // R8

endmodule

// File: rtl/cnv_word_shift.sv
module cnv_word_shift #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              kill,
  input  logic              sclk_fall,
  input  logic              sclk_rise,
  output logic              dout
);

  localparam int BW = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [BW-1:0]     cnt_q, cnt_d;
  logic              act_q, act_d;
  logic              dout_q, dout_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    dout_d = dout_q;
    if (kill) begin
      act_d  = 1'b0;
      dout_d = 1'b1;
    end else if (load) begin
      sh_d   = word;
      cnt_d  = '0;
      act_d  = 1'b1;
      dout_d = 1'b0;
    end else if (act_q) begin
      if (sclk_fall && (cnt_q < BW'(WORD_W))) begin
        dout_d = sh_q[WORD_W-1];
        sh_d   = {sh_q[WORD_W-2:0], 1'b0};
        cnt_d  = cnt_q + 1'b1;
      end else if (sclk_rise && (cnt_q == BW'(WORD_W))) begin
        act_d  = 1'b0;
        dout_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      dout_q <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;

  AST_LINE_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill && !load && !sclk_fall && !sclk_rise) |=> $stable(dout)); // R5
  AST_DONE_RAISES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && sclk_rise && (cnt_q == BW'(WORD_W)) && !kill && !load) |=> dout); // R7

endmodule

// File: rtl/rdy_word_seq.sv
module rdy_word_seq
  import rdy_seq_pkg::*;
#(
  parameter int PER_FAST    = 3840,
  parameter int PER_SLOW    = 6400,
  parameter int WAKE_TICKS  = 64,
  parameter int EARLY_TICKS = 32,
  parameter int SETTLE_FAST = 2,
  parameter int SETTLE_SLOW = 3
) (
  input  logic              clk,
  input  logic              pd_n,
  input  logic              sclk,
  input  logic              rate_sel,
  input  logic              gain_sel,
  input  logic              res_valid,
  input  logic [CODE_W-1:0] res_code,
  input  logic              res_ovr,
  output logic              dr_out,
  output logic              dr_oe,
  output logic              bridge_on
);

  localparam int PIN_W = 3;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [PIN_W-1:0]  pin_q, pin_qd;
  logic              sclk_fall, sclk_rise, cfg_chg;
  logic              publish, early, in_conv, kill;
  logic [CODE_W-1:0] hold_code_q;
  logic              hold_ovr_q;
  logic [WORD_W-1:0] word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge pd_n) begin
    if (!pd_n) rst_sync_q <= '0;
    else       rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];
  assign dr_oe     = rst_int_n;
  assign bridge_on = rst_int_n;

  cnv_pin_sync #(.W(PIN_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  ({sclk, rate_sel, gain_sel}),
    .q    (pin_q),
    .q_d  (pin_qd)
  );

  assign sclk_fall = pin_qd[2] & ~pin_q[2];
  assign sclk_rise = ~pin_qd[2] & pin_q[2];
  assign cfg_chg   = (pin_q[1:0] != pin_qd[1:0]);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hold_code_q <= '0;
      hold_ovr_q  <= 1'b0;
    end else if (res_valid) begin
      hold_code_q <= res_code;
      hold_ovr_q  <= res_ovr;
    end
  end

  cnv_period_ctrl #(
    .PER_FAST   (PER_FAST),
    .PER_SLOW   (PER_SLOW),
    .WAKE_TICKS (WAKE_TICKS),
    .EARLY_TICKS(EARLY_TICKS),
    .SETTLE_FAST(SETTLE_FAST),
    .SETTLE_SLOW(SETTLE_SLOW)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .slow_sel(pin_q[1]),
    .restart (cfg_chg),
    .publish (publish),
    .early   (early),
    .in_conv (in_conv)
  );

  assign kill = cfg_chg | early;
  assign word = {hold_code_q, status_byte(pin_q[1], hold_ovr_q, pin_q[0])};

  cnv_word_shift #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (publish),
    .word     (word),
    .kill     (kill),
    .sclk_fall(sclk_fall),
    .sclk_rise(sclk_rise),
    .dout     (dr_out)
  );

  AST_CFG_EDGE_RAISES_LINE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_chg && in_conv) |=> dr_out); // R2
  AST_PUBLISH_LOWERS_LINE: assert property (@(posedge clk) disable iff (!rst_int_n)
    publish |=> !dr_out); // R5
  AST_WITHDRAW_RAISES_LINE: assert property (@(posedge clk) disable iff (!rst_int_n)
    early |=> dr_out); // R8

endmodule

// File: tb/rdy_word_seq_test.sv
module rdy_word_seq_test;

  localparam int CLK_P = 10;
  localparam int PF    = 400;
  localparam int PS    = 640;
  localparam int WAKE  = 50;
  localparam int EARLY = 20;

  logic        clk = 1'b0;
  logic        pd_n = 1'b0;
  logic        sclk = 1'b1;
  logic        rate = 1'b0;
  logic        gain = 1'b1;
  logic        rv = 1'b0;
  logic [23:0] rc = '0;
  logic        ro = 1'b0;
  logic        dr_out, dr_oe, bridge_on;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  rdy_word_seq #(
    .PER_FAST(PF), .PER_SLOW(PS), .WAKE_TICKS(WAKE), .EARLY_TICKS(EARLY),
    .SETTLE_FAST(2), .SETTLE_SLOW(3)
  ) uut (
    .clk(clk), .pd_n(pd_n), .sclk(sclk), .rate_sel(rate), .gain_sel(gain),
    .res_valid(rv), .res_code(rc), .res_ovr(ro),
    .dr_out(dr_out), .dr_oe(dr_oe), .bridge_on(bridge_on)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural timing model ----------------
  logic [2:0]  h1 = '0, h2 = '0, h3 = '0;
  int          m_up = 0, m_wake = 0, m_el = 0, m_cnt = 0;
  bit          m_conv = 0, m_have = 0;
  logic        m_dout = 1'b1;
  logic [31:0] m_word = '0;
  logic [23:0] m_hcode = '0;
  logic        m_hovr = 1'b0;

  always @(posedge clk) begin : model
    logic chg, fall, rise, kill, load;
    int per, stl, n;
    if (!pd_n) begin
      m_up = 0; m_conv = 0; m_wake = 0; m_have = 0; m_dout = 1'b1;
      m_hcode = '0; m_hovr = 1'b0;
    end else begin
      if (m_up >= 2) begin
        chg  = (h2[1:0] != h3[1:0]);
        fall = h3[2] & ~h2[2];
        rise = ~h3[2] & h2[2];
        per  = h2[1] ? PS : PF;
        stl  = h2[1] ? 3 : 2;
        kill = chg;
        load = 1'b0;
        if (!m_conv) begin
          if (m_wake == WAKE - 1) begin m_conv = 1; m_el = 0; end
          else m_wake++;
        end else if (chg) begin
          m_el = 0;
        end else begin
          n = m_el + 1;
          if ((n % per == 0) && (n / per >= stl)) load = 1'b1;
          if (n % per == per - EARLY) kill = 1'b1;
          m_el = n;
        end
        if (kill) begin
          m_have = 0; m_dout = 1'b1;
        end else if (load) begin
          m_word = {m_hcode, 1'b0, h2[1], m_hovr, 2'b01, h2[0], 2'b01};
          m_have = 1; m_cnt = 0; m_dout = 1'b0;
        end else if (m_have) begin
          if (fall && m_cnt < 32) begin
            m_dout = m_word[31 - m_cnt];
            m_cnt++;
          end else if (rise && m_cnt == 32) begin
            m_have = 0; m_dout = 1'b1;
          end
        end
        if (rv) begin m_hcode = rc; m_hovr = ro; end
      end else begin
        m_hcode = '0; m_hovr = 1'b0;
      end
      if (m_up < 2) m_up++;
    end
    h3 = h2; h2 = h1; h1 = {sclk, rate, gain};
  end

  // compare every cycle, away from the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    chk("R3 dr_oe per-cycle", {31'b0, dr_oe}, {31'b0, (m_up >= 2)});
    chk("R3 bridge_on per-cycle", {31'b0, bridge_on}, {31'b0, (m_up >= 2)});
    if (m_up >= 2) chk("R5 dr_out per-cycle vs model", {31'b0, dr_out}, {31'b0, m_dout});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete actual=%0d expected<=150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // ---------------- host helpers ----------------
  task automatic wait_ready();
    while (dr_out !== 1'b0) @(negedge clk);
  endtask

  task automatic measure_to_ready(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (dr_out !== 1'b0);
  endtask

  task automatic read_bits(input int nb, output logic [31:0] w);
    w = '0;
    for (int i = 0; i < nb; i++) begin
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      w = {w[30:0], dr_out};
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic load_result(input logic [23:0] code, input logic ovr);
    rc = code; ro = ovr; rv = 1'b1;
    @(negedge clk);
    rv = 1'b0;
  endtask

  initial begin
    logic [31:0] w;
    int n, lo, hi;
    repeat (5) @(negedge clk);
    chk("R3 dr_oe low in power-down", {31'b0, dr_oe}, 32'd0);
    chk("R3 bridge open in power-down", {31'b0, bridge_on}, 32'd0);

    pd_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 dr_oe after release", {31'b0, dr_oe}, 32'd1);
    chk("R4 bridge closed after release", {31'b0, bridge_on}, 32'd1);
    chk("R4 line high while waking", {31'b0, dr_out}, 32'd1);
    load_result(24'h123456, 1'b0);
    measure_to_ready(n);
    chk("R4 R1 wake plus fast settle", n + 3, WAKE + 2 + 2 * PF);

    read_bits(32, w);
    chk("R5 R6 R10 first word", w, {24'h123456, 8'h0D});
    repeat (4) @(negedge clk);
    chk("R7 line high after full read", {31'b0, dr_out}, 32'd1);
    sclk = 1'b0; repeat (4) @(negedge clk);
    chk("R7 extra sclk edge ignored", {31'b0, dr_out}, 32'd1);
    sclk = 1'b1; repeat (4) @(negedge clk);

    load_result(24'h000000, 1'b1);
    wait_ready();
    read_bits(32, w);
    chk("R10 R6 negative full scale with range error", w, {24'h000000, 8'h2D});

    wait_ready();
    lo = 0; while (dr_out === 1'b0) begin lo++; @(negedge clk); end
    hi = 0; while (dr_out === 1'b1) begin hi++; @(negedge clk); end
    chk("R11 unread word low time", lo, PF - EARLY);
    chk("R8 withdrawal window", hi, EARLY);

    load_result(24'hFFFFFF, 1'b0);
    rate = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 rate edge raises line", {31'b0, dr_out}, 32'd1);
    measure_to_ready(n);
    chk("R1 R2 slow settle after rate edge", n + 3, 3 + 3 * PS);
    read_bits(32, w);
    chk("R10 R6 positive full scale slow rate", w, {24'hFFFFFF, 8'h4D});

    load_result(24'h800000, 1'b0);
    wait_ready();
    read_bits(8, w);
    chk("R5 partial read top byte", w, 32'h80);
    gain = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 gain edge raises line", {31'b0, dr_out}, 32'd1);
    measure_to_ready(n);
    chk("R1 R2 settle after gain edge", n + 3, 3 + 3 * PS);
    read_bits(32, w);
    chk("R9 R10 R6 word restarts at MSB, gain 128", w, {24'h800000, 8'h49});

    wait_ready();
    read_bits(10, w);
    while (dr_out === 1'b0) @(negedge clk);
    sclk = 1'b0; repeat (4) @(negedge clk);
    chk("R8 sclk during withdrawal ignored", {31'b0, dr_out}, 32'd1);
    sclk = 1'b1; repeat (4) @(negedge clk);
    wait_ready();
    read_bits(32, w);
    chk("R9 full word after lost partial read", w, {24'h800000, 8'h49});

    @(negedge clk);
    pd_n = 1'b0;
    #1;
    chk("R3 short pulse drops dr_oe at once", {31'b0, dr_oe}, 32'd0);
    chk("R3 short pulse opens bridge", {31'b0, bridge_on}, 32'd0);
    @(negedge clk);
    pd_n = 1'b1;
    measure_to_ready(n);
    chk("R4 R1 wake plus slow settle after pulse", n, WAKE + 2 + 3 * PS);
    read_bits(32, w);
    chk("R10 hold cleared by reset", w, {24'h000000, 8'h49});

    repeat (10) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule